// File: doc/BRIEF.md
# DMA Request-to-Channel Router

This block sits between a set of peripheral request lines and a bank of DMA channels. Each request line has its own small map register. The register says whether the line is routed at all, and if so, to which channel. Every clock cycle the router gathers the request levels onto their target channels. It keeps one active flag per channel and compares the new level against that flag. When a channel's level rises, the router emits a one-cycle request-after-stop pulse. When it falls, the router emits a one-cycle end-of-receive pulse. A status unit consumes both pulses.

Software programs the map registers through a 32-bit register port. The registers sit in two address windows: a low window for the first sixty-four requests and a high window for the remainder. Three request-status addresses are decoded as read-as-zero locations. A map write that names a channel outside the configured channel count is stored anyway, and it raises a one-cycle error pulse. The per-channel active flags leave the block as a vector for the transfer engine.

Top module: `dreq_router`

## Requirements
- R1: After reset, every map register reads zero and `chan_req`, `ras_evt`, `eor_evt` and `map_err` are all zero.
- R2: A map register holds bits 7..0 of the written word. Bit 7 is the valid flag and bits 4..0 are the channel number. A read returns the stored byte with bits 31..8 zero.
- R3: Map register n, for n from 0 to 63, sits at byte address 0x100 + 4*n.
- R4: Map register n, for n from 64 to NUM_REQ-1, sits at byte address 0x1100 + 4*(n-64). Slots in that window beyond the last request read zero.
- R5: `reg_rdata` presents the read result in the cycle after `reg_rd` is sampled high, and it holds its value while no read is issued.
- R6: Addresses 0xE0, 0xE4 and 0xE8 always read zero. A write to them changes no map register.
- R7: A request whose map valid flag is 0 has no effect on any channel flag or event.
- R8: `chan_req[c]` equals, one cycle after sampling, the OR of all requests that have a valid map naming channel c.
- R9: A 0-to-1 change of a channel flag gives exactly one cycle of `ras_evt` on that channel, in the same cycle the flag rises.
- R10: A 1-to-0 change of a channel flag gives exactly one cycle of `eor_evt` on that channel, in the same cycle the flag falls.
- R11: A channel never shows `ras_evt` and `eor_evt` together. While its flag is steady, it shows neither.
- R12: A map write with the valid flag set and a channel number at or above NUM_CH gives a one-cycle `map_err` pulse in the next cycle, and the value is still stored.
- R13: When several requests share a channel, a second request rising raises no new event. The channel falls only when the last of them drops.
- R14: A map write takes effect for routing from the cycle after the write. A request sampled in the write cycle uses the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| map_err | output | 1 | Pulse: a valid map named a channel out of range |
| req_in | input | NUM_REQ | Peripheral request levels |
| chan_req | output | NUM_CH | Per-channel request-active flags |
| ras_evt | output | NUM_CH | Request-after-stop pulses |
| eor_evt | output | NUM_CH | End-of-receive pulses |

## Verification
A map rewrite and a request edge on the same request line can land in the same clock edge. The bench provokes this by driving the new map word and the request rise in one cycle. It then expects the old channel to rise with a request-after-stop pulse. One cycle later it expects the old channel to fall with an end-of-receive pulse, while the new channel rises with its own request-after-stop pulse. This confirms that routing always uses the map value registered before the edge.

// File: rtl/dreq_router_pkg.sv
package dreq_router_pkg;
   localparam int MAP_W      = 8;
   localparam int CH_FIELD_W = 5;
   localparam int IDX_W      = 7;
   localparam int LO_COUNT   = 64;
   localparam int STAT_COUNT = 3;
   localparam logic [7:0]  LO_PAGE   = 8'h01;
   localparam logic [7:0]  HI_PAGE   = 8'h11;
   localparam logic [15:0] STAT_BASE = 16'h00E0;

   typedef struct packed {
      logic                  valid;
      logic [1:0]            spare;
      logic [CH_FIELD_W-1:0] chan;
   } map_t;
endpackage

// File: rtl/dreq_addr_dec.sv
module dreq_addr_dec
   import dreq_router_pkg::*;
#(
   parameter int NUM_REQ = 75
) (
   input  logic [15:0]      addr,
   output logic             map_hit,
   output logic [IDX_W-1:0] map_idx,
   output logic             stat_hit
);
   logic             aligned;
   logic             lo_page, hi_page;
   logic [IDX_W-1:0] cand;
   logic [STAT_COUNT-1:0] stat_vec;

   always_comb begin
      aligned = (addr[1:0] == 2'b00);
      lo_page = (addr[15:8] == LO_PAGE);
      hi_page = (addr[15:8] == HI_PAGE);
      cand    = {hi_page, addr[7:2]};
      map_idx = cand;
      map_hit = aligned && (lo_page || hi_page) && (int'(cand) < NUM_REQ);
   end

   for (genvar s = 0; s < STAT_COUNT; s++) begin : g_stat
      assign stat_vec[s] = (addr == STAT_BASE + 16'(4 * s));
   end

   assign stat_hit = |stat_vec;
endmodule

// File: rtl/dreq_map_bank.sv
module dreq_map_bank
   import dreq_router_pkg::*;
#(
   parameter int NUM_REQ = 75,
   parameter int NUM_CH  = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [MAP_W-1:0]         wr_data,
   input  logic                     rd_en,
   input  logic                     rd_hit,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [31:0]              rdata,
   output map_t [NUM_REQ-1:0]       maps,
   output logic                     err
);
   map_t wr_map;
   map_t rd_sel;
   logic err_q;
   logic [31:0] rdata_q;

   assign wr_map = map_t'(wr_data);

   for (genvar r = 0; r < NUM_REQ; r++) begin : g_map
      always_ff @(posedge clk) begin
         if (!rst_n)
            maps[r] <= '0;
         else if (wr_en && wr_idx == IDX_W'(r))
            maps[r] <= wr_map;
      end
   end

   always_comb begin
      rd_sel = '0;
      for (int r = 0; r < NUM_REQ; r++)
         if (rd_idx == IDX_W'(r)) rd_sel = maps[r];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         err_q <= wr_en && wr_map.valid && (int'(wr_map.chan) >= NUM_CH);
         if (rd_en)
            rdata_q <= rd_hit ? {{(32-MAP_W){1'b0}}, rd_sel} : 32'h0;
      end
   end

   assign err   = err_q;
   assign rdata = rdata_q;

   a_r12_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(wr_en));
   a_r5_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en) |-> $stable(rdata));
endmodule

// File: rtl/dreq_chan_edge.sv
module dreq_chan_edge
   import dreq_router_pkg::*;
#(
   parameter int NUM_REQ = 75,
   parameter int NUM_CH  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  map_t [NUM_REQ-1:0]  maps,
   input  logic [NUM_REQ-1:0]  req_in,
   output logic [NUM_CH-1:0]   flag,
   output logic [NUM_CH-1:0]   ras,
   output logic [NUM_CH-1:0]   eor
);
   logic [NUM_CH-1:0] lvl;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int r = 0; r < NUM_REQ; r++)
            if (maps[r].valid && req_in[r] && maps[r].chan == CH_FIELD_W'(c))
               hit = 1'b1;
      end
      assign lvl[c] = hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= '0;
         ras  <= '0;
         eor  <= '0;
      end else begin
         flag <= lvl;
         ras  <= lvl & ~flag;
         eor  <= ~lvl & flag;
      end
   end

   a_r9_ras_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ras == (flag & ~$past(flag)));
   a_r10_eor_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      eor == (~flag & $past(flag)));
   a_r11_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      (ras & eor) == '0);
endmodule

// File: rtl/dreq_router.sv
module dreq_router
   import dreq_router_pkg::*;
#(
   parameter int NUM_REQ = 75,
   parameter int NUM_CH  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [15:0]        reg_addr,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               map_err,
   input  logic [NUM_REQ-1:0] req_in,
   output logic [NUM_CH-1:0]  chan_req,
   output logic [NUM_CH-1:0]  ras_evt,
   output logic [NUM_CH-1:0]  eor_evt
);
   if (NUM_REQ < 1 || NUM_REQ > 2 * LO_COUNT) begin : g_bad_req
      $error("dreq_router: NUM_REQ out of range");
   end
   if (NUM_CH < 1 || NUM_CH > (1 << CH_FIELD_W)) begin : g_bad_ch
      $error("dreq_router: NUM_CH out of range");
   end

   logic             map_hit, stat_hit;
   logic [IDX_W-1:0] map_idx;
   map_t [NUM_REQ-1:0] maps;
   logic unused_wdata;

   assign unused_wdata = ^reg_wdata[31:MAP_W];

   dreq_addr_dec #(.NUM_REQ(NUM_REQ)) u_dec (
      .addr     (reg_addr),
      .map_hit  (map_hit),
      .map_idx  (map_idx),
      .stat_hit (stat_hit)
   );

   dreq_map_bank #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && map_hit),
      .wr_idx  (map_idx),
      .wr_data (reg_wdata[MAP_W-1:0]),
      .rd_en   (reg_rd),
      .rd_hit  (map_hit),
      .rd_idx  (map_idx),
      .rdata   (reg_rdata),
      .maps    (maps),
      .err     (map_err)
   );

   dreq_chan_edge #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .maps   (maps),
      .req_in (req_in),
      .flag   (chan_req),
      .ras    (ras_evt),
      .eor    (eor_evt)
   );

   a_r6_status_not_map: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_hit && map_hit));
   a_r6_status_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_rd && stat_hit) |-> reg_rdata == 32'h0);
endmodule

// File: tb/dreq_router_test.sv
module dreq_router_test;
   localparam int NREQ = 75;
   localparam int NCH  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       reg_addr = '0;
   logic              reg_wr = 1'b0;
   logic              reg_rd = 1'b0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              map_err;
   logic [NREQ-1:0]   req_in = '0;
   logic [NCH-1:0]    chan_req, ras_evt, eor_evt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct { logic [31:0] exp; string tag; } item_t;
   item_t sbq[$];

   always #10 clk = ~clk;

   dreq_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .map_err(map_err), .req_in(req_in), .chan_req(chan_req),
      .ras_evt(ras_evt), .eor_evt(eor_evt)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Scoreboard monitor: compares read data one cycle after the strobe
   always @(posedge clk) begin
      if (reg_rd === 1'b1) begin
         #2;
         if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(reg_rdata, it.exp, it.tag);
         end
      end
   end

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      it.exp = exp; it.tag = tag;
      sbq.push_back(it);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic set_req(input int idx, input logic v);
      @(negedge clk);
      req_in[idx] = v;
      @(negedge clk);
   endtask

   function automatic logic [31:0] bit_of(input int c);
      return 32'(1) << c;
   endfunction

   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(32'(chan_req), 0, "R1 chan_req");
      check(32'(ras_evt), 0, "R1 ras_evt");
      check(32'(eor_evt), 0, "R1 eor_evt");
      check(32'(map_err), 0, "R1 map_err");
      rd(16'h0100, 0, "R1 map0 reset");
      rd(16'h1118, 0, "R1 map70 reset");

      // R2, R3 low window
      wr(16'h010C, 32'h0000_008A);
      rd(16'h010C, 32'h8A, "R3 map3 readback");
      wr(16'h0114, 32'hFFFF_FF85);
      rd(16'h0114, 32'h85, "R2 upper bits dropped");
      // R4 high window
      wr(16'h1118, 32'h82);
      rd(16'h1118, 32'h82, "R4 map70 readback");
      rd(16'h112C, 0, "R4 slot past last request");
      // R5 read data held with no read
      @(negedge clk);
      check(reg_rdata, 0, "R5 rdata held");
      // R6 status locations
      wr(16'h00E4, 32'hFFFF_FFFF);
      rd(16'h00E0, 0, "R6 status0");
      rd(16'h00E4, 0, "R6 status1");
      rd(16'h00E8, 0, "R6 status2");
      rd(16'h0100, 0, "R6 map0 untouched");
      rd(16'h0104, 0, "R6 map1 untouched");

      // R7 invalid map ignored
      wr(16'h0104, 32'h07);
      set_req(1, 1'b1);
      check(32'(chan_req), 0, "R7 no channel flag");
      check(32'(ras_evt), 0, "R7 no event");

      // R8, R9, R10 single request on channel 10
      set_req(3, 1'b1);
      check(32'(chan_req), bit_of(10), "R8 chan10 active");
      check(32'(ras_evt), bit_of(10), "R9 ras pulse");
      @(negedge clk);
      check(32'(ras_evt), 0, "R9 ras single cycle");
      check(32'(eor_evt), 0, "R11 steady no event");
      set_req(3, 1'b0);
      check(32'(chan_req), 0, "R8 chan10 inactive");
      check(32'(eor_evt), bit_of(10), "R10 eor pulse");
      check(32'(ras_evt), 0, "R11 no ras with eor");
      @(negedge clk);
      check(32'(eor_evt), 0, "R10 eor single cycle");

      // R13 shared channel 2: requests 70 and 20
      wr(16'h0150, 32'h82);
      set_req(70, 1'b1);
      check(32'(ras_evt), bit_of(2), "R13 first rise");
      set_req(20, 1'b1);
      check(32'(ras_evt), 0, "R13 second rise silent");
      check(32'(chan_req), bit_of(2), "R13 chan2 active");
      set_req(70, 1'b0);
      check(32'(chan_req), bit_of(2), "R13 still active");
      check(32'(eor_evt), 0, "R13 no early eor");
      set_req(20, 1'b0);
      check(32'(eor_evt), bit_of(2), "R13 last drop eor");

      // R12 out-of-range channel
      wr(16'h0124, 32'h93);
      check(32'(map_err), 1, "R12 error pulse");
      @(negedge clk);
      check(32'(map_err), 0, "R12 pulse one cycle");
      rd(16'h0124, 32'h93, "R12 value stored");
      wr(16'h0124, 32'h13);
      check(32'(map_err), 0, "R12 invalid map no error");
      set_req(9, 1'b1);
      check(32'(chan_req), 0, "R12 out-of-range routes nowhere");

      // R14 map rewrite in the same cycle as the request rise
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 16'h010C; reg_wdata = 32'h84; req_in[3] = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      check(32'(chan_req), bit_of(10), "R14 old mapping used");
      check(32'(ras_evt), bit_of(10), "R14 old channel ras");
      @(negedge clk);
      check(32'(chan_req), bit_of(4), "R14 new mapping used");
      check(32'(ras_evt), bit_of(4), "R14 new channel ras");
      check(32'(eor_evt), bit_of(10), "R14 old channel eor");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule